// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus when a target device is stuck holding SDA low, for example after a transfer was cut off partway through a byte. On each request it toggles SCL a programmed number of times and never drives SDA. A target that is partway through shifting out a byte therefore gets the clocks it needs to finish and let go of SDA. The block also reports the sampled levels of both lines, so software can see whether the bus has recovered.

Software owns the retry policy. A typical loop works like this:

1. Apply the unit reset.
2. Read the SDA level. If SDA is low, request a single-pulse burst and wait for busy to drop.
3. Read SDA again, and repeat up to nine times.

SDA is monitored through an optional glitch filter. The filter can be bypassed, because it delays line edges and that delay disturbs repeated START timing. SCL pulses use a fixed half period taken from a parameter that is sized for standard-mode timing.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset, busy is 0, scl_oe is 0, and sda_level and scl_level read 1 while both lines are high.
- R2: scl_level shows the value of scl_in one clock after the clock edge that samples it. When filt_bypass is 1, sda_level does the same for sda_in.
- R3: When filt_bypass is 0, sda_level takes a new value only after the sampled SDA has differed from it for 2 consecutive clocks. It therefore follows a change of sda_in 3 clocks later, and a low pulse lasting 1 clock never reaches it.
- R4: When idle, a cycle with rst_req at 1 and a nonzero pulse_cnt (unsigned) starts a burst of pulse_cnt SCL pulses. Each pulse has scl_oe at 1 for HALF_CYC clocks and then at 0 for HALF_CYC clocks. busy stays 1 for exactly 2·HALF_CYC·pulse_cnt clocks and then returns to 0.
- R5: A request with pulse_cnt equal to 0 produces no pulse, and busy stays 0.
- R6: A request that arrives while busy is 1 is ignored, so the burst in progress emits exactly its original number of pulses.
- R7: unit_rst returns the block to idle on the next clock, with busy and scl_oe both 0. It takes priority over a request in the same cycle.
- R8: pulse_cnt is captured when the burst starts, so changing it during a burst has no effect on the number of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_rst | input | 1 | Synchronous return to idle |
| rst_req | input | 1 | One-cycle bus-clear request |
| pulse_cnt | input | CNT_W | Number of SCL pulses per request |
| filt_bypass | input | 1 | 1 bypasses the SDA glitch filter |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (open drain) |
| busy | output | 1 | High while a burst is in progress |
| sda_level | output | 1 | Monitored SDA level |
| scl_level | output | 1 | Monitored SCL level |

## Verification
The bench runs bursts with counts of 1, 2, 3, 7, the maximum 15, and 0. Measuring both the pulse count and the busy duration separates three faults: an off-by-one in the pulse counter, a wrong half period, and a burst that fails to start or stop.

SDA is tested with a step, a 1-clock glitch and a 2-clock glitch, both with the filter enabled and with it bypassed. Together these show the exact filter latency and where its rejection threshold lies.

Two disturbances are injected during a burst:
- A second request carrying a different count, to confirm that requests are ignored while busy and that the count was latched at the start.
- A unit reset asserted together with a request, to confirm that the unit reset aborts the burst and wins over the request.

A recovery loop is also run against a target model that releases SDA after three pulses. The loop must stop after exactly three requests.

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
  parameter int HALF_CYC     = 625,
  parameter int CNT_W        = 4,
  parameter int FILT_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_rst,
  input  logic             rst_req,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic             filt_bypass,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             busy,
  output logic             sda_level,
  output logic             scl_level
);

  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int FW = $clog2(FILT_SAMPLES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYC - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FILT_SAMPLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [CNT_W-1:0] left;
  logic             scl_s, sda_s, sda_f;
  logic [FW-1:0]    stab;

  wire half_done = (tmr == T_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_f <= 1'b1;
      stab  <= '0;
    end else if (unit_rst) begin
      sda_f <= 1'b1;
      stab  <= '0;
    end else if (sda_s != sda_f) begin
      if (stab == F_LAST) begin
        sda_f <= sda_s;
        stab  <= '0;
      end else begin
        stab  <= stab + 1'b1;
      end
    end else begin
      stab <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      tmr  <= '0;
      left <= '0;
    end else if (unit_rst) begin
      st   <= S_IDLE;
      tmr  <= '0;
      left <= '0;
    end else begin
      unique case (st)
        S_IDLE:
          if (rst_req && pulse_cnt != '0) begin
            st   <= S_LOW;
            left <= pulse_cnt;
            tmr  <= '0;
          end
        S_LOW:
          if (half_done) begin
            st  <= S_HIGH;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_HIGH:
          if (half_done) begin
            tmr <= '0;
            if (left == CNT_W'(1)) begin
              st   <= S_IDLE;
              left <= '0;
            end else begin
              st   <= S_LOW;
              left <= left - 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end

  assign scl_oe    = (st == S_LOW);
  assign busy      = (st != S_IDLE);
  assign scl_level = scl_s;
  assign sda_level = filt_bypass ? sda_s : sda_f;

  p_burst_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> scl_oe);

  p_ends_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy && !scl_oe));

  p_zero_count_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rst_req && pulse_cnt == '0 && !unit_rst) |=> !busy);

  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_rst) |=> (left <= $past(left)));

  p_unit_rst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst |=> (!busy && !scl_oe));

  p_filter_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_f != $past(sda_f) && !$past(unit_rst)) |->
      ($past(sda_s) == sda_f && $past(sda_s, 2) == sda_f));

endmodule

// File: tb/sim_bus_clear_seq.sv
module sim_bus_clear_seq;
  localparam int HALF = 8;
  localparam int CW   = 4;

  logic clk = 0, rst_n = 0, unit_rst = 0, rst_req = 0, filt_bypass = 1;
  logic [CW-1:0] pulse_cnt = '0;
  logic scl_hold = 0, sda_hold = 0;
  wire  scl_oe, busy, sda_level, scl_level;
  wire  scl_in = ~(scl_oe | scl_hold);
  wire  sda_in = ~sda_hold;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  bus_clear_seq #(.HALF_CYC(HALF), .CNT_W(CW), .FILT_SAMPLES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .unit_rst(unit_rst), .rst_req(rst_req),
    .pulse_cnt(pulse_cnt), .filt_bypass(filt_bypass), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .busy(busy), .sda_level(sda_level),
    .scl_level(scl_level));

  localparam int NV = 6;
  localparam int VEC_CNT [NV] = '{1, 2, 3, 7, 15, 0};
  localparam int VEC_EXP [NV] = '{1, 2, 3, 7, 15, 0};

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  // kind 1: second request with count 9; kind 2: unit reset plus request
  task automatic burst(input int cnt, input int inj_at, input int kind,
                       output int pulses, output int cycles);
    logic prev;
    @(negedge clk); pulse_cnt = CW'(cnt); rst_req = 1;
    @(negedge clk); rst_req = 0;
    pulses = 0; cycles = 0; prev = 0;
    for (int i = 0; i < 100000; i++) begin
      if (!busy) break;
      cycles++;
      if (scl_oe && !prev) pulses++;
      prev = scl_oe;
      if (i == inj_at) begin
        rst_req = 1;
        if (kind == 1) pulse_cnt = 4'd9;
        else unit_rst = 1;
      end
      @(negedge clk); rst_req = 0; unit_rst = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    int p, c, tries;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_level", sda_level, 1);
    chk("R1 scl_level", scl_level, 1);

    for (int v = 0; v < NV; v++) begin
      burst(VEC_CNT[v], -1, 0, p, c);
      chk(VEC_CNT[v] == 0 ? "R5 pulses" : "R4 pulses", p, VEC_EXP[v]);
      chk(VEC_CNT[v] == 0 ? "R5 busy cycles" : "R4 busy cycles", c, 2 * HALF * VEC_EXP[v]);
      @(negedge clk);
      chk("R4 idle after burst", busy, 0);
    end

    burst(3, 5, 1, p, c);
    chk("R6 R8 pulses with request while busy", p, 3);
    chk("R6 R8 busy cycles", c, 6 * HALF);

    burst(4, HALF + 3, 2, p, c);
    chk("R7 cycles until abort", c, HALF + 4);
    chk("R7 busy", busy, 0);
    chk("R7 scl_oe", scl_oe, 0);
    repeat (3) @(negedge clk);
    chk("R7 request dominated", busy, 0);

    filt_bypass = 1;
    scl_hold = 1;
    chk("R2 scl before edge", scl_level, 1);
    @(negedge clk);
    chk("R2 scl after edge", scl_level, 0);
    scl_hold = 0;
    @(negedge clk);
    chk("R2 scl released", scl_level, 1);
    sda_hold = 1;
    @(negedge clk);
    chk("R2 sda bypass", sda_level, 0);
    sda_hold = 0;
    @(negedge clk);
    chk("R2 sda bypass high", sda_level, 1);

    filt_bypass = 0;
    repeat (4) @(negedge clk);
    sda_hold = 1;
    @(negedge clk); @(negedge clk);
    chk("R3 sda filtered not yet", sda_level, 1);
    @(negedge clk);
    chk("R3 sda filtered low", sda_level, 0);
    sda_hold = 0;
    repeat (4) @(negedge clk);
    chk("R3 sda filtered high", sda_level, 1);
    sda_hold = 1;
    @(negedge clk); sda_hold = 0;
    begin
      int lowseen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!sda_level) lowseen = 1;
      end
      chk("R3 one-clock glitch rejected", lowseen, 0);
    end
    sda_hold = 1;
    @(negedge clk); @(negedge clk); sda_hold = 0;
    @(negedge clk);
    chk("R3 two-clock pulse passes", sda_level, 0);
    repeat (4) @(negedge clk);

    filt_bypass = 1;
    sda_hold = 1;
    @(negedge clk);
    tries = 0;
    for (int t = 0; t < 9; t++) begin
      if (sda_level) break;
      burst(1, -1, 0, p, c);
      tries++;
      if (tries == 3) sda_hold = 0;
      @(negedge clk); @(negedge clk);
    end
    chk("R4 recovery tries", tries, 3);
    chk("R4 sda freed", sda_level, 1);

    report();
    $finish;
  end
endmodule